// File: doc/BRIEF.md
# Address Quadrant Context Selector

This block is the first stage of a two-stage radix address translation unit. For each request it receives a 64-bit effective address, a hypervisor-mode flag, an access type and the current values of the partition-ID and process-ID registers. It reads the top two address bits as a quadrant. From the quadrant and the mode it picks the partition/process ID pair that the table walk will use. When the guest uses a quadrant it may not use, it reports a segment-class fault instead.

For a fault the block states the interrupt class. On a data access it also supplies the effective address that should be captured into the data address register. Results are registered and appear one cycle after the request, marked by a one-cycle valid pulse. A request whose access-type code is undefined is reported as an error and yields no ID pair.

Top module: `qsel_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_ok`, `out_fault`, `out_addr_we` are 0 and all data outputs are zero.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1 at the clock edge, so each request produces one pulse.
- R3: The quadrant is address bits [63:62]. No other address bit changes the selected IDs or the fault decision.
- R4: With `req_hv`=1: quadrant 0 gives partition 0 with the process-ID register, quadrant 1 gives both registers, quadrant 2 gives the partition-ID register with process 0, and quadrant 3 gives both IDs zero. `out_ok`=1 in all four cases.
- R5: With `req_hv`=0: quadrant 0 gives both registers, and quadrant 3 gives the partition-ID register with process 0. `out_ok`=1 in both cases.
- R6: With `req_hv`=0, quadrants 1 and 2 set `out_fault`=1 and `out_ok`=0, and both ID outputs are zero.
- R7: A segment fault on an instruction fetch (`req_acc`=2'b00) reports class 2'b01 (instruction segment), with `out_addr_we`=0 and `out_fault_addr` zero.
- R8: A segment fault on a load (2'b01) or store (2'b10) reports class 2'b10 (data segment), with `out_addr_we`=1 and `out_fault_addr` equal to the request address.
- R9: `out_err` is zero for every segment fault and for every successful selection.
- R10: `req_acc`=2'b11 is undefined. It takes precedence over the quadrant and reports class 2'b11, `out_err`=1, `out_ok`=0, `out_fault`=0, `out_addr_we`=0 and zero IDs.
- R11: When `out_valid` is 0, every other output is zero. When `out_valid` is 1, exactly one of these holds: `out_ok`, `out_fault`, or class 2'b11. Class is 2'b00 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 64 | Effective address |
| req_hv | input | 1 | Hypervisor-mode flag |
| req_acc | input | 2 | Access type: 00 fetch, 01 load, 10 store, 11 undefined |
| lpid_reg | input | 12 | Current partition-ID register |
| pid_reg | input | 20 | Current process-ID register |
| out_valid | output | 1 | One-cycle result strobe |
| out_ok | output | 1 | ID pair is valid |
| out_lpid | output | 12 | Selected partition ID |
| out_pid | output | 20 | Selected process ID |
| out_fault | output | 1 | Segment-class fault |
| out_class | output | 2 | 00 none, 01 instruction segment, 10 data segment, 11 bad access type |
| out_fault_addr | output | 64 | Address to capture into the data address register |
| out_addr_we | output | 1 | Capture strobe for the data address register |
| out_err | output | 4 | Error code (0 on segment faults) |

## Verification
Some properties are checked by assertions on every cycle:
- the response timing;
- that the three outcomes never overlap;
- that outputs are silent when no result is valid;
- the zero error code on faults;
- the pairing of the capture strobe with the data-segment class;
- the illegal guest quadrants;
- the hypervisor quadrant-0 selection.

Other properties show up only in the bench's scenarios. The bench sweeps every mode, quadrant and access code against several address and register patterns:
- the full ID table in both modes;
- that low address bits do not affect the decision;
- the captured address value;
- the precedence of the undefined access code over an illegal quadrant.

// File: rtl/qsel_pkg.sv
package qsel_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_UNDEF = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        INT_NONE   = 2'b00,
        INT_ISEG   = 2'b01,
        INT_DSEG   = 2'b10,
        INT_BADACC = 2'b11
    } int_e;

    // Which register values a quadrant hands to the walker
    typedef struct packed {
        logic legal;
        logic take_lpid;
        logic take_pid;
    } idsel_t;

    localparam int QUAD_W = 2;

    function automatic idsel_t quad_select(input logic hv, input logic [QUAD_W-1:0] q);
        idsel_t s;
        s = '0;
        if (hv) begin
            s.legal     = 1'b1;
            s.take_lpid = (q == 2'd1) || (q == 2'd2);
            s.take_pid  = (q == 2'd0) || (q == 2'd1);
        end else begin
            s.legal     = (q == 2'd0) || (q == 2'd3);
            s.take_lpid = s.legal;
            s.take_pid  = (q == 2'd0);
        end
        return s;
    endfunction

    function automatic logic acc_defined(input logic [1:0] a);
        return a != ACC_UNDEF;
    endfunction

endpackage

// File: rtl/qsel_quad_dec.sv
module qsel_quad_dec
    import qsel_pkg::*;
(
    input  logic [QUAD_W-1:0] quad,
    input  logic              hv,
    output idsel_t            sel
);
    always_comb begin
        sel = quad_select(hv, quad);
    end
endmodule

// File: rtl/qsel_fault_cls.sv
module qsel_fault_cls
    import qsel_pkg::*;
#(
    parameter int EA_W  = 64,
    parameter int ERR_W = 4
) (
    input  logic             acc_ok,
    input  logic             seg_fault,
    input  logic [1:0]       acc,
    input  logic [EA_W-1:0]  ea,
    output int_e             cls,
    output logic [EA_W-1:0]  fault_addr,
    output logic             addr_we,
    output logic [ERR_W-1:0] err
);
    localparam logic [ERR_W-1:0] ERR_BADACC = ERR_W'(1);

    always_comb begin
        cls        = INT_NONE;
        fault_addr = '0;
        addr_we    = 1'b0;
        err        = '0;
        if (!acc_ok) begin
            cls = INT_BADACC;
            err = ERR_BADACC;
        end else if (seg_fault) begin
            if (acc == ACC_FETCH) begin
                cls = INT_ISEG;
            end else begin
                cls        = INT_DSEG;
                fault_addr = ea;
                addr_we    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/qsel_top.sv
module qsel_top
    import qsel_pkg::*;
#(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic              req_hv,
    input  logic [1:0]        req_acc,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic              out_valid,
    output logic              out_ok,
    output logic [LPID_W-1:0] out_lpid,
    output logic [PID_W-1:0]  out_pid,
    output logic              out_fault,
    output logic [1:0]        out_class,
    output logic [EA_W-1:0]   out_fault_addr,
    output logic              out_addr_we,
    output logic [ERR_W-1:0]  out_err
);
    localparam int QMSB = EA_W - 1;

    logic [QUAD_W-1:0] quad;
    idsel_t            sel;
    logic              acc_ok;
    logic              ok_n;
    logic              seg_n;
    logic [LPID_W-1:0] lpid_n;
    logic [PID_W-1:0]  pid_n;
    int_e              cls_n;
    logic [EA_W-1:0]   faddr_n;
    logic              we_n;
    logic [ERR_W-1:0]  err_n;

    assign quad = req_ea[QMSB -: QUAD_W];

    qsel_quad_dec u_dec (
        .quad (quad),
        .hv   (req_hv),
        .sel  (sel)
    );

    always_comb begin
        acc_ok = acc_defined(req_acc);
        ok_n   = acc_ok && sel.legal;
        seg_n  = acc_ok && !sel.legal;
        lpid_n = (ok_n && sel.take_lpid) ? lpid_reg : '0;
        pid_n  = (ok_n && sel.take_pid)  ? pid_reg  : '0;
    end

    qsel_fault_cls #(.EA_W(EA_W), .ERR_W(ERR_W)) u_cls (
        .acc_ok     (acc_ok),
        .seg_fault  (seg_n),
        .acc        (req_acc),
        .ea         (req_ea),
        .cls        (cls_n),
        .fault_addr (faddr_n),
        .addr_we    (we_n),
        .err        (err_n)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            out_valid      <= 1'b0;
            out_ok         <= 1'b0;
            out_lpid       <= '0;
            out_pid        <= '0;
            out_fault      <= 1'b0;
            out_class      <= INT_NONE;
            out_fault_addr <= '0;
            out_addr_we    <= 1'b0;
            out_err        <= '0;
        end else begin
            out_valid      <= 1'b1;
            out_ok         <= ok_n;
            out_lpid       <= lpid_n;
            out_pid        <= pid_n;
            out_fault      <= seg_n;
            out_class      <= cls_n;
            out_fault_addr <= faddr_n;
            out_addr_we    <= we_n;
            out_err        <= err_n;
        end
    end
endmodule

// File: rtl/qsel_chk.sv
module qsel_chk #(
    parameter int EA_W   = 64,
    parameter int LPID_W = 12,
    parameter int PID_W  = 20,
    parameter int ERR_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [EA_W-1:0]   req_ea,
    input logic              req_hv,
    input logic [1:0]        req_acc,
    input logic [PID_W-1:0]  pid_reg,
    input logic              out_valid,
    input logic              out_ok,
    input logic [LPID_W-1:0] out_lpid,
    input logic [PID_W-1:0]  out_pid,
    input logic              out_fault,
    input logic [1:0]        out_class,
    input logic [EA_W-1:0]   out_fault_addr,
    input logic              out_addr_we,
    input logic [ERR_W-1:0]  out_err
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(req_valid)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_ok && !out_fault && !out_addr_we && out_lpid == '0
                        && out_pid == '0 && out_class == 2'b00
                        && out_fault_addr == '0 && out_err == '0));

    // R11
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones({out_ok, out_fault, out_class == 2'b11}) == 1));

    // R9
    seg_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fault || out_ok) |-> (out_err == '0));

    // R8
    capture_dseg_chk: assert property (@(posedge clk) disable iff (rst)
        out_addr_we |-> (out_fault && out_class == 2'b10));

    // R6
    guest_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && !$past(req_hv) && $past(req_acc) != 2'b11
         && ($past(req_ea[EA_W-1 -: 2]) == 2'd1 || $past(req_ea[EA_W-1 -: 2]) == 2'd2))
        |-> (out_fault && !out_ok));

    // R4
    hv_q0_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && $past(req_hv) && $past(req_acc) != 2'b11
         && $past(req_ea[EA_W-1 -: 2]) == 2'd0)
        |-> (out_ok && out_lpid == '0 && out_pid == $past(pid_reg)));
endmodule

bind qsel_top qsel_chk #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/tb_qsel_top.sv
module tb_qsel_top;
    localparam int EA_W = 64, LPID_W = 12, PID_W = 20, ERR_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [EA_W-1:0] req_ea = '0;
    logic req_hv = 1'b0;
    logic [1:0] req_acc = 2'b00;
    logic [LPID_W-1:0] lpid_reg = '0;
    logic [PID_W-1:0] pid_reg = '0;
    logic out_valid, out_ok, out_fault, out_addr_we;
    logic [LPID_W-1:0] out_lpid;
    logic [PID_W-1:0] out_pid;
    logic [1:0] out_class;
    logic [EA_W-1:0] out_fault_addr;
    logic [ERR_W-1:0] out_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qsel_top #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .ERR_W(ERR_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea), .req_hv(req_hv),
        .req_acc(req_acc), .lpid_reg(lpid_reg), .pid_reg(pid_reg),
        .out_valid(out_valid), .out_ok(out_ok), .out_lpid(out_lpid), .out_pid(out_pid),
        .out_fault(out_fault), .out_class(out_class), .out_fault_addr(out_fault_addr),
        .out_addr_we(out_addr_we), .out_err(out_err));

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, "valid", 64'(out_valid), 64'd0);
        check(req, "ok", 64'(out_ok), 64'd0);
        check(req, "fault", 64'(out_fault), 64'd0);
        check(req, "we", 64'(out_addr_we), 64'd0);
        check(req, "ids", {out_lpid, out_pid}, 64'd0);
        check(req, "class", 64'(out_class), 64'd0);
        check(req, "addr", out_fault_addr, 64'd0);
        check(req, "err", 64'(out_err), 64'd0);
    endtask

    // expected values for the request currently held on the inputs
    logic            e_ok, e_fault, e_we;
    logic [LPID_W-1:0] e_lpid;
    logic [PID_W-1:0]  e_pid;
    logic [1:0]      e_cls;
    logic [63:0]     e_addr;
    logic [ERR_W-1:0] e_err;

    task automatic compute_expect();
        logic [1:0] q;
        q = req_ea[63:62];
        e_ok = 0; e_fault = 0; e_we = 0; e_lpid = '0; e_pid = '0;
        e_cls = 2'b00; e_addr = '0; e_err = '0;
        if (req_acc == 2'b11) begin
            e_cls = 2'b11; e_err = 1;
        end else if (req_hv) begin
            e_ok = 1;
            if (q == 1 || q == 2) e_lpid = lpid_reg;
            if (q == 0 || q == 1) e_pid = pid_reg;
        end else if (q == 0 || q == 3) begin
            e_ok = 1; e_lpid = lpid_reg;
            if (q == 0) e_pid = pid_reg;
        end else begin
            e_fault = 1;
            if (req_acc == 2'b00) e_cls = 2'b01;
            else begin e_cls = 2'b10; e_we = 1; e_addr = req_ea; end
        end
    endtask

    task automatic check_result(input logic [1:0] q, input logic hv, input logic [1:0] a);
        string rid;
        rid = (a == 2'b11) ? "R10" : (hv ? "R4" : ((q == 0 || q == 3) ? "R5" : "R6"));
        check("R2", "valid", 64'(out_valid), 64'd1);
        check(rid, "ok", 64'(out_ok), 64'(e_ok));
        check(rid, "lpid", 64'(out_lpid), 64'(e_lpid));
        check(rid, "pid", 64'(out_pid), 64'(e_pid));
        check(rid, "fault", 64'(out_fault), 64'(e_fault));
        check((a == 2'b00) ? "R7" : "R8", "class", 64'(out_class), 64'(e_cls));
        check((a == 2'b00) ? "R7" : "R8", "addr", out_fault_addr, e_addr);
        check((a == 2'b00) ? "R7" : "R8", "we", 64'(out_addr_we), 64'(e_we));
        check((a == 2'b11) ? "R10" : "R9", "err", 64'(out_err), 64'(e_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        // back-to-back sweep: R3 via varied low address bits
        for (int p = 0; p < 4; p++) begin
            for (int hv = 0; hv < 2; hv++) begin
                for (int q = 0; q < 4; q++) begin
                    for (int a = 0; a < 4; a++) begin
                        logic [61:0] low;
                        logic [1:0] qq, aa;
                        low = (p == 0) ? 62'd0 : (p == 1) ? {62{1'b1}} :
                              (p == 2) ? 62'h2AAA_5555_1234_ABCD : 62'(64'h1 << (p * 13 + q * 3));
                        qq = 2'(q); aa = 2'(a);
                        req_valid = 1'b1;
                        req_ea    = {qq, low};
                        req_hv    = 1'(hv);
                        req_acc   = aa;
                        lpid_reg  = 12'(12'hA5C ^ (p * 37 + q));
                        pid_reg   = 20'(20'h5_3C1A ^ (p * 911 + a * 7));
                        compute_expect();
                        @(negedge clk);
                        check_result(qq, 1'(hv), aa);
                    end
                end
            end
        end
        // request strobe dropped: single pulse, quiet outputs (R2, R11)
        req_valid = 1'b0;
        req_ea = {2'b01, 62'h1};
        req_acc = 2'b01;
        req_hv = 1'b0;
        @(negedge clk);
        check_idle("R11");
        @(negedge clk);
        check_idle("R2");
        // isolated request after gap, then pulse ends (R2, R8)
        req_valid = 1'b1;
        req_ea = 64'h8000_0000_DEAD_BEEF;
        req_acc = 2'b10;
        compute_expect();
        @(negedge clk);
        req_valid = 1'b0;
        check_result(2'd2, 1'b0, 2'b10);
        @(negedge clk);
        check_idle("R2");
        // reset mid-stream clears outputs (R1)
        req_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1");
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule